// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block holds a small set of recent virtual-page to physical-page mappings in front of a page table walker. On every lookup it compares the requested virtual page number against all entries in parallel. One cycle later it reports one of three results. A hit returns the physical page number, the protection bits and the dirty state of the matching entry. A miss asks the walker for a table walk. A fault reports a write to a page that has no write permission.

The walker writes its results back through a fill port. A fill goes to the entry that already holds the same tag if there is one. Otherwise it goes to the lowest-numbered free entry. When the buffer is full, a round-robin victim pointer picks the entry to replace.

Software-visible changes to mappings arrive in two ways. A single-page invalidate removes one tag. A context-switch flush drops every entry that is not marked global.

A write that hits a page without write permission faults and leaves the entry unchanged. This lets the first write to a page be trapped. After the walker refills the entry with write permission, later writes hit cleanly and simply set the dirty bit again.

Top module: `xlat_cache`

## Requirements
- R1: Each lookup request produces `rsp_valid` exactly one cycle later, with exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault` high; after reset `rsp_valid` is low and every entry is invalid.
- R2: A hit returns the stored physical page number, protection bits (bit 0 write allowed, bit 1 execute allowed, bit 2 user access) and dirty bit of the matching entry.
- R3: A lookup whose tag is in no valid entry reports a miss, never a fault, including a lookup in the same cycle as the fill of that tag; a lookup after the fill hits.
- R4: A write lookup hitting an entry with write bit set reports a hit and sets that entry's dirty bit; repeated writes keep hitting without a fault.
- R5: A write lookup hitting an entry with write bit clear reports a fault (hit low) and leaves the entry unchanged, so its dirty bit stays clear.
- R6: A read lookup to an entry without write permission reports a hit.
- R7: A single-page invalidate removes only the entry holding the given tag; other entries keep hitting.
- R8: A context-switch flush invalidates every entry whose global bit is clear and keeps every global entry.
- R9: A fill whose tag matches no entry is written to the lowest-numbered invalid entry.
- R10: When all entries are valid, a fill of a new tag replaces the entry at the round-robin pointer, which starts at entry 0 after reset and advances by one after each such replacement.
- R11: A fill in the same cycle as an invalidate of the same tag is not written; a fill with an invalidate of another tag is written.
- R12: A fill whose tag is already present overwrites that entry, so a later lookup returns the new data and no tag is held twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_vpn | input | 20 | Lookup virtual page number |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_miss | output | 1 | Lookup missed, walk needed |
| rsp_fault | output | 1 | Write to page without write permission |
| rsp_ppn | output | 24 | Physical page number on hit |
| rsp_prot | output | 3 | Protection bits on hit |
| rsp_dirty | output | 1 | Dirty bit on hit |
| fill_en | input | 1 | Write a walk result |
| fill_vpn | input | 20 | Fill virtual page number |
| fill_ppn | input | 24 | Fill physical page number |
| fill_prot | input | 3 | Fill protection bits |
| fill_global | input | 1 | Fill entry survives context flush |
| fill_dirty | input | 1 | Fill dirty bit |
| inv_en | input | 1 | Single-page invalidate |
| inv_vpn | input | 20 | Page to invalidate |
| flush_ctx | input | 1 | Context-switch flush |

## Verification
A fill and an invalidate can arrive in the same cycle. The bench drives both on one edge, first with equal tags and then with different tags. It judges the result by later lookups: the colliding fill must miss, and the unrelated fill must hit. A lookup can also share its cycle with the fill of its own tag. The bench provokes this case and expects a miss on that response, followed by a hit on the next lookup.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VPN_W  = 20;
    localparam int PPN_W  = 24;
    localparam int PROT_W = 3;

    // bit 0 write, bit 1 execute, bit 2 user
    typedef struct packed {
        logic user;
        logic exec;
        logic wr;
    } prot_t;

    typedef struct packed {
        logic             valid;
        logic             glob;
        logic             dirty;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
        prot_t            prot;
    } entry_t;

    typedef enum logic [1:0] {
        RES_MISS  = 2'd0,
        RES_HIT   = 2'd1,
        RES_FAULT = 2'd2
    } result_e;

    function automatic entry_t make_entry(input logic [VPN_W-1:0] vpn,
                                          input logic [PPN_W-1:0] ppn,
                                          input logic [PROT_W-1:0] prot,
                                          input logic glob,
                                          input logic dirty);
        entry_t e;
        e.valid = 1'b1;
        e.glob  = glob;
        e.dirty = dirty;
        e.vpn   = vpn;
        e.ppn   = ppn;
        e.prot  = prot_t'(prot);
        return e;
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int N = 16
) (
    input  entry_t           ent [N],
    input  logic [VPN_W-1:0] vpn,
    output logic [N-1:0]     hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = ent[i].valid && (ent[i].vpn == vpn);
    end
endmodule

// File: rtl/xlat_alloc.sv
module xlat_alloc #(
    parameter int N = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fill_go,
    input  logic [N-1:0] valid,
    input  logic [N-1:0] same,
    output logic [N-1:0] tgt
);
    logic [IW-1:0] rr_q;
    logic [N-1:0]  first_free;
    logic          any_free;
    logic          evict;

    always_comb begin
        first_free = '0;
        any_free   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !any_free) begin
                first_free[i] = 1'b1;
                any_free      = 1'b1;
            end
        end
    end

    assign evict = !(|same) && !any_free;

    always_comb begin
        if (|same)         tgt = same;
        else if (any_free) tgt = first_free;
        else               tgt = N'(1) << rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (fill_go && evict) begin
            rr_q <= (rr_q == IW'(N - 1)) ? '0 : rr_q + IW'(1);
        end
    end

    // R9 R10 R12: a fill always lands in exactly one entry
    a_r10_onehot_target: assert property (@(posedge clk) disable iff (rst)
        fill_go |-> $onehot(tgt));

endmodule

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] dirty_set,
    input  logic [N-1:0] deny,
    input  logic         flush_ctx,
    input  logic [N-1:0] inv_hit,
    input  logic         fill_go,
    input  logic         fill_blk,
    input  logic [N-1:0] tgt,
    input  entry_t       fill_ent,
    output entry_t       ent_q [N]
);
    for (genvar i = 0; i < N; i++) begin : g_ent
        entry_t nxt;
        logic   wr_here;

        assign wr_here = fill_go && tgt[i];

        always_comb begin
            nxt = ent_q[i];
            if (dirty_set[i])                   nxt.dirty = 1'b1;
            if (flush_ctx && !ent_q[i].glob)    nxt.valid = 1'b0;
            if (inv_hit[i])                     nxt.valid = 1'b0;
            if (wr_here)                        nxt       = fill_ent;
        end

        always_ff @(posedge clk) begin
            if (rst) ent_q[i] <= '0;
            else     ent_q[i] <= nxt;
        end

        // R8: flush drops non-global entries
        a_r8_flush_clears: assert property (@(posedge clk) disable iff (rst)
            ($past(flush_ctx) && !$past(ent_q[i].glob) && !$past(wr_here))
            |-> !ent_q[i].valid);

        // R8: global entries survive a flush
        a_r8_global_kept: assert property (@(posedge clk) disable iff (rst)
            ($past(flush_ctx) && $past(ent_q[i].valid) && $past(ent_q[i].glob)
             && !$past(inv_hit[i]) && !$past(wr_here))
            |-> ent_q[i].valid);

        // R5: a denied write leaves the entry as it was
        a_r5_fault_no_change: assert property (@(posedge clk) disable iff (rst)
            ($past(deny[i]) && !$past(flush_ctx) && !$past(inv_hit[i]) && !$past(wr_here))
            |-> (ent_q[i] == $past(ent_q[i])));

        // R11: a fill cancelled by an invalidate of its tag leaves no entry for it
        a_r11_inv_wins: assert property (@(posedge clk) disable iff (rst)
            $past(fill_blk) |-> !(ent_q[i].valid && ent_q[i].vpn == $past(fill_ent.vpn)));
    end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_req,
    input  logic             lk_write,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_miss,
    output logic             rsp_fault,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic [PROT_W-1:0] rsp_prot,
    output logic             rsp_dirty,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [PROT_W-1:0] fill_prot,
    input  logic             fill_global,
    input  logic             fill_dirty,
    input  logic             inv_en,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             flush_ctx
);
    localparam int N = ENTRIES;

    entry_t       ent [N];
    logic [N-1:0] lk_hit, inv_m, fill_m, inv_hit;
    logic [N-1:0] valid_v, dirty_set, deny, tgt;
    logic         fill_blk, fill_go;
    entry_t       fill_ent;
    entry_t       sel;
    result_e      res;

    xlat_match #(.N(N)) i_m_lk   (.ent(ent), .vpn(lk_vpn),   .hit(lk_hit));
    xlat_match #(.N(N)) i_m_inv  (.ent(ent), .vpn(inv_vpn),  .hit(inv_m));
    xlat_match #(.N(N)) i_m_fill (.ent(ent), .vpn(fill_vpn), .hit(fill_m));

    for (genvar i = 0; i < N; i++) begin : g_vec
        assign valid_v[i]   = ent[i].valid;
        assign dirty_set[i] = lk_req && lk_write && lk_hit[i] && ent[i].prot.wr;
        assign deny[i]      = lk_req && lk_write && lk_hit[i] && !ent[i].prot.wr;
    end

    assign inv_hit  = inv_en ? inv_m : '0;
    assign fill_blk = fill_en && inv_en && (inv_vpn == fill_vpn);
    assign fill_go  = fill_en && !fill_blk;
    assign fill_ent = make_entry(fill_vpn, fill_ppn, fill_prot, fill_global, fill_dirty);

    xlat_alloc #(.N(N)) i_alloc (
        .clk(clk), .rst(rst), .fill_go(fill_go),
        .valid(valid_v), .same(fill_m), .tgt(tgt)
    );

    xlat_store #(.N(N)) i_store (
        .clk(clk), .rst(rst), .dirty_set(dirty_set), .deny(deny),
        .flush_ctx(flush_ctx), .inv_hit(inv_hit), .fill_go(fill_go),
        .fill_blk(fill_blk), .tgt(tgt), .fill_ent(fill_ent), .ent_q(ent)
    );

    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (lk_hit[i]) sel = sel | ent[i];
        end
        if (!(|lk_hit))          res = RES_MISS;
        else if (|deny)          res = RES_FAULT;
        else                     res = RES_HIT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_miss  <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_ppn   <= '0;
            rsp_prot  <= '0;
            rsp_dirty <= 1'b0;
        end else begin
            rsp_valid <= lk_req;
            rsp_hit   <= lk_req && (res == RES_HIT);
            rsp_miss  <= lk_req && (res == RES_MISS);
            rsp_fault <= lk_req && (res == RES_FAULT);
            if (lk_req && res == RES_HIT) begin
                rsp_ppn   <= sel.ppn;
                rsp_prot  <= sel.prot;
                rsp_dirty <= sel.dirty;
            end else begin
                rsp_ppn   <= '0;
                rsp_prot  <= '0;
                rsp_dirty <= 1'b0;
            end
        end
    end

    // R1: a valid response carries exactly one outcome
    a_r1_one_outcome: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

    // R1: responses follow requests by one cycle
    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> rsp_valid);

    // R12: no tag is ever held in two entries
    a_r12_no_duplicate: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_hit));

    // R3: a miss is never reported alongside a fault or hit outcome
    a_r3_miss_alone: assert property (@(posedge clk) disable iff (rst)
        rsp_miss |-> (!rsp_fault && !rsp_hit));

endmodule

// File: tb/test_xlat_cache.sv
module test_xlat_cache;
    import xlat_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic             lk_req = 0, lk_write = 0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic             rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
    logic [PPN_W-1:0] rsp_ppn;
    logic [PROT_W-1:0] rsp_prot;
    logic             fill_en = 0, fill_global = 0, fill_dirty = 0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PPN_W-1:0] fill_ppn = '0;
    logic [PROT_W-1:0] fill_prot = '0;
    logic             inv_en = 0, flush_ctx = 0;
    logic [VPN_W-1:0] inv_vpn = '0;

    int n_chk = 0, n_bad = 0;

    xlat_cache #(.ENTRIES(16)) i_xlat_cache (
        .clk(clk), .rst(rst), .lk_req(lk_req), .lk_write(lk_write), .lk_vpn(lk_vpn),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_ppn(rsp_ppn), .rsp_prot(rsp_prot),
        .rsp_dirty(rsp_dirty), .fill_en(fill_en), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_prot(fill_prot), .fill_global(fill_global),
        .fill_dirty(fill_dirty), .inv_en(inv_en), .inv_vpn(inv_vpn),
        .flush_ctx(flush_ctx)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_fill(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] p,
                           input logic [2:0] pr, input logic g);
        fill_en = 1; fill_vpn = v; fill_ppn = p; fill_prot = pr; fill_global = g; fill_dirty = 0;
        @(negedge clk);
        fill_en = 0;
    endtask

    task automatic do_inv(input logic [VPN_W-1:0] v);
        inv_en = 1; inv_vpn = v;
        @(negedge clk);
        inv_en = 0;
    endtask

    // outcome code: 1 hit, 0 miss, 2 fault
    task automatic look(input logic [VPN_W-1:0] v, input logic w, output logic [1:0] oc);
        lk_req = 1; lk_write = w; lk_vpn = v;
        @(negedge clk);
        lk_req = 0; lk_write = 0;
        oc = rsp_fault ? 2'd2 : (rsp_hit ? 2'd1 : 2'd0);
    endtask

    task automatic t_reset();
        logic [1:0] oc;
        do_reset();
        chk("R1 reset rsp_valid", 64'(rsp_valid), 0);
        look(20'h00000, 0, oc);
        chk("R1 reset lookup misses", 64'(oc), 0);
        chk("R1 rsp_valid after request", 64'(rsp_valid), 1);
        @(negedge clk);
        chk("R1 rsp_valid drops", 64'(rsp_valid), 0);
    endtask

    task automatic t_fill_hit();
        logic [1:0] oc;
        do_reset();
        look(20'h12345, 0, oc);
        chk("R3 miss before fill", 64'(oc), 0);
        chk("R3 no fault on miss", 64'(rsp_fault), 0);
        do_fill(20'h12345, 24'hABCDEF, 3'b101, 0);
        look(20'h12345, 0, oc);
        chk("R3 hit after fill", 64'(oc), 1);
        chk("R2 ppn", 64'(rsp_ppn), 64'hABCDEF);
        chk("R2 prot", 64'(rsp_prot), 64'h5);
        chk("R2 dirty", 64'(rsp_dirty), 0);
        do_fill(20'h00777, 24'h000123, 3'b010, 0);
        look(20'h00777, 0, oc);
        chk("R2 second ppn", 64'(rsp_ppn), 64'h123);
        chk("R2 second prot", 64'(rsp_prot), 64'h2);
    endtask

    task automatic t_dirty();
        logic [1:0] oc;
        do_reset();
        do_fill(20'h00A00, 24'h000A00, 3'b000, 0);
        look(20'h00A00, 0, oc);
        chk("R6 read of read-only hits", 64'(oc), 1);
        look(20'h00A00, 1, oc);
        chk("R5 write to read-only faults", 64'(oc), 2);
        chk("R5 hit low on fault", 64'(rsp_hit), 0);
        look(20'h00A00, 0, oc);
        chk("R5 entry unchanged dirty", 64'(rsp_dirty), 0);
        chk("R5 entry unchanged ppn", 64'(rsp_ppn), 64'hA00);
        do_fill(20'h00A00, 24'h000A00, 3'b001, 0);
        look(20'h00A00, 1, oc);
        chk("R4 first write hits", 64'(oc), 1);
        look(20'h00A00, 1, oc);
        chk("R4 repeated write hits", 64'(oc), 1);
        chk("R4 dirty set", 64'(rsp_dirty), 1);
        look(20'h00A00, 0, oc);
        chk("R4 dirty kept", 64'(rsp_dirty), 1);
    endtask

    task automatic t_inv();
        logic [1:0] oc;
        do_reset();
        do_fill(20'h00100, 24'h1, 3'b001, 0);
        do_fill(20'h00200, 24'h2, 3'b001, 1);
        do_inv(20'h00100);
        look(20'h00100, 0, oc);
        chk("R7 invalidated page misses", 64'(oc), 0);
        look(20'h00200, 0, oc);
        chk("R7 other page kept", 64'(oc), 1);
        do_inv(20'h00200);
        look(20'h00200, 0, oc);
        chk("R7 global page invalidated", 64'(oc), 0);
    endtask

    task automatic t_flush();
        logic [1:0] oc;
        do_reset();
        do_fill(20'h00300, 24'h3, 3'b001, 1);
        do_fill(20'h00400, 24'h4, 3'b001, 0);
        do_fill(20'h00500, 24'h5, 3'b000, 0);
        flush_ctx = 1;
        @(negedge clk);
        flush_ctx = 0;
        look(20'h00300, 0, oc);
        chk("R8 global survives", 64'(oc), 1);
        chk("R8 global ppn", 64'(rsp_ppn), 3);
        look(20'h00400, 0, oc);
        chk("R8 non-global cleared", 64'(oc), 0);
        look(20'h00500, 0, oc);
        chk("R8 non-global cleared 2", 64'(oc), 0);
    endtask

    task automatic t_replace();
        logic [1:0] oc;
        do_reset();
        for (int i = 0; i < 16; i++) do_fill(20'h10 + 20'(i), 24'(i), 3'b001, 0);
        do_inv(20'h15);
        do_inv(20'h17);
        do_fill(20'h40, 24'h40, 3'b001, 0);
        do_fill(20'h41, 24'h41, 3'b001, 0);
        for (int i = 0; i < 16; i++) begin
            look(20'h10 + 20'(i), 0, oc);
            chk("R9 free slots reused, full set kept", 64'(oc),
                (i == 5 || i == 7) ? 0 : 1);
        end
        do_fill(20'h42, 24'h42, 3'b001, 0);
        do_fill(20'h43, 24'h43, 3'b001, 0);
        look(20'h10, 0, oc);
        chk("R10 first victim entry 0", 64'(oc), 0);
        look(20'h11, 0, oc);
        chk("R10 second victim entry 1", 64'(oc), 0);
        look(20'h12, 0, oc);
        chk("R10 entry 2 kept", 64'(oc), 1);
        look(20'h41, 0, oc);
        chk("R9 fill in freed slot", 64'(oc), 1);
        look(20'h43, 0, oc);
        chk("R10 replacement hits", 64'(rsp_ppn), 64'h43);
    endtask

    task automatic t_collide();
        logic [1:0] oc;
        do_reset();
        fill_en = 1; fill_vpn = 20'h00600; fill_ppn = 24'h6; fill_prot = 3'b001;
        inv_en = 1; inv_vpn = 20'h00600;
        @(negedge clk);
        fill_en = 0; inv_en = 0;
        look(20'h00600, 0, oc);
        chk("R11 fill cancelled by invalidate", 64'(oc), 0);
        fill_en = 1; fill_vpn = 20'h00700; fill_ppn = 24'h7;
        inv_en = 1; inv_vpn = 20'h00800;
        lk_req = 1; lk_vpn = 20'h00700;
        @(negedge clk);
        fill_en = 0; inv_en = 0; lk_req = 0;
        chk("R3 lookup in fill cycle misses", 64'(rsp_miss), 1);
        look(20'h00700, 0, oc);
        chk("R11 unrelated invalidate keeps fill", 64'(oc), 1);
    endtask

    task automatic t_overwrite();
        logic [1:0] oc;
        do_reset();
        do_fill(20'h00900, 24'h900, 3'b001, 0);
        do_fill(20'h00900, 24'h901, 3'b100, 0);
        look(20'h00900, 0, oc);
        chk("R12 new ppn", 64'(rsp_ppn), 64'h901);
        chk("R12 new prot", 64'(rsp_prot), 64'h4);
        do_inv(20'h00900);
        look(20'h00900, 0, oc);
        chk("R12 single copy removed", 64'(oc), 0);
    endtask

    bit finished = 0;

    initial begin
        t_reset();
        t_fill_hit();
        t_dirty();
        t_inv();
        t_flush();
        t_replace();
        t_collide();
        t_overwrite();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule